// File: doc/BRIEF.md
# Banked Scratch RAM with Upward Stack

This block is the 128-byte on-chip working store of a small 8-bit controller core. Three ways into the same storage coexist. A byte port reaches any location by its 7-bit address. A register port takes a 3-bit register number and places it inside one of four eight-byte banks; the bank comes from a 2-bit selector that the core drives from its status word. A bit port names one of 128 single bits in the sixteen bytes that start at 20h, and can read or write that bit alone.

A built-in stack pointer gives push and pop in the same storage, with the stack growing toward higher addresses. All reads are combinational views of the current contents. Every write takes effect at the rising clock edge. When several writers aim at the same byte in one cycle, a fixed priority decides which one lands. Writers aimed at different bytes all land in the same cycle.

Top module: `banked_scratch_ram`

## Requirements
- R1: After reset every byte reads 00h, `sp_out` is 07h and `pop_data` shows byte 07h.
- R2: A register-port access with bank selector k and register number n reaches byte address 8·k + n, that is {k[1:0], n[2:0]}. `reg_rdata` shows that byte, and `reg_we` writes `reg_wdata` into it at the clock edge.
- R3: `byte_rdata` always shows the byte at `byte_addr`. When `byte_we` is high, `byte_wdata` is stored there at the clock edge.
- R4: Bit address b (00h to 7Fh) names bit b[2:0] of byte 20h + b[6:3]. `bit_rdata` shows that bit, so bit address 7Fh is bit 7 of byte 2Fh.
- R5: When `bit_we` is high, `bit_wval` is stored into the named bit and the other seven bits of that byte are kept.
- R6: When several ports write the same byte in one cycle, the byte port beats the register port, and both beat the bit port.
- R7: A push (`push_req` high, `pop_req` low) first adds one to the stack pointer and then stores `push_data` at the new pointer, so the first push after reset writes byte 08h. `pop_data` always shows the byte at the pointer.
- R8: A pop (`pop_req` high, `push_req` low) leaves the contents unchanged and subtracts one from the stack pointer, so `pop_data` then shows the byte below.
- R9: A push wins over any byte, register or bit write to the same byte in the same cycle.
- R10: When `push_req` and `pop_req` are both high, neither the pointer nor the storage is changed by the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Register bank chosen by the status word |
| byte_addr | input | 7 | Byte port address |
| byte_wdata | input | 8 | Byte port write data |
| byte_we | input | 1 | Byte port write enable |
| byte_rdata | output | 8 | Byte at `byte_addr` |
| reg_num | input | 3 | Register number inside the bank |
| reg_wdata | input | 8 | Register port write data |
| reg_we | input | 1 | Register port write enable |
| reg_rdata | output | 8 | Byte of the selected register |
| bit_addr | input | 7 | Address of one bit in the bit region |
| bit_we | input | 1 | Bit write enable |
| bit_wval | input | 1 | Value to store in the bit |
| bit_rdata | output | 1 | Current value of the addressed bit |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Data to push |
| pop_req | input | 1 | Pop request |
| pop_data | output | 8 | Byte at the stack pointer |
| sp_out | output | 8 | Current stack pointer |

## Verification
Three kinds of write can meet on one byte in the same cycle: a push against a byte-port write, a byte-port write against a bit write in the bit region, and a byte-port write against a register-port write. The bench provokes each case by aiming two ports at the same address in the same cycle. After the edge it reads the byte back through the byte port and expects the value from the higher-priority writer. A push and a pop raised together are judged the same way: the pointer and the neighbouring byte must be unchanged afterwards.

// File: rtl/bram_pkg.sv
package bram_pkg;

   // Stack action resolved from the two request lines
   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;

   // Which writer owns a row in a given cycle, highest priority first
   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_STACK = 3'd1,
      SRC_BYTE  = 3'd2,
      SRC_REG   = 3'd3,
      SRC_BIT   = 3'd4
   } wr_src_e;

endpackage

// File: rtl/bram_stack_ctrl.sv
module bram_stack_ctrl
   import bram_pkg::*;
#(
   parameter int SP_W     = 8,
   parameter int ADDR_W   = 7,
   parameter int SP_RESET = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   output stk_op_e           op,
   output logic [SP_W-1:0]   sp,
   output logic [ADDR_W-1:0] push_addr,
   output logic [ADDR_W-1:0] top_addr
);

   localparam logic [SP_W-1:0] SP_INIT = SP_W'(SP_RESET);
   localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);

   logic [SP_W-1:0] sp_inc;
   logic [SP_W-1:0] sp_dec;

   always_comb begin
      op = STK_IDLE;
      if (push_req && !pop_req) op = STK_PUSH;
      else if (pop_req && !push_req) op = STK_POP;
   end

   assign sp_inc    = sp + SP_ONE;
   assign sp_dec    = sp - SP_ONE;
   assign push_addr = sp_inc[ADDR_W-1:0];
   assign top_addr  = sp[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= SP_INIT;
      end else begin
         case (op)
            STK_PUSH: sp <= sp_inc;
            STK_POP:  sp <= sp_dec;
            default:  sp <= sp;
         endcase
      end
   end

endmodule

// File: rtl/bram_decode.sv
module bram_decode #(
   parameter int ADDR_W    = 7,
   parameter int BANK_W    = 2,
   parameter int REG_W     = 3,
   parameter int BITADDR_W = 7,
   parameter int BITPOS_W  = 3,
   parameter int BIT_BASE  = 32
) (
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic [REG_W-1:0]     reg_num,
   input  logic [BITADDR_W-1:0] bit_addr,
   output logic [ADDR_W-1:0]    reg_addr,
   output logic [ADDR_W-1:0]    bit_byte,
   output logic [BITPOS_W-1:0]  bit_pos
);

   localparam int              BANKREG_W = BANK_W + REG_W;
   localparam int              BYTESEL_W = BITADDR_W - BITPOS_W;
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BIT_BASE);

   logic [BANKREG_W-1:0] bank_reg;
   logic [BYTESEL_W-1:0] byte_sel;

   // Bank bits sit above the register number
   assign bank_reg = {bank_sel, reg_num};
   assign reg_addr = ADDR_W'(bank_reg);

   // Upper bit-address bits pick the byte, lower ones the bit in it
   assign byte_sel = bit_addr[BITADDR_W-1:BITPOS_W];
   assign bit_pos  = bit_addr[BITPOS_W-1:0];
   assign bit_byte = BASE_A + ADDR_W'(byte_sel);

endmodule

// File: rtl/bram_store.sv
module bram_store
   import bram_pkg::*;
#(
   parameter int DEPTH       = 128,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int BITPOS_W    = 3,
   parameter int NRD         = 4,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stk_we,
   input  logic [ADDR_W-1:0]   stk_addr,
   input  logic [DATA_W-1:0]   stk_data,
   input  logic                byte_we,
   input  logic [ADDR_W-1:0]   byte_addr,
   input  logic [DATA_W-1:0]   byte_data,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_data,
   input  logic                bit_we,
   input  logic [ADDR_W-1:0]   bit_byte,
   input  logic [BITPOS_W-1:0] bit_pos,
   input  logic                bit_val,
   input  logic [ADDR_W-1:0]   rd_addr [NRD],
   output logic [DATA_W-1:0]   rd_data [NRD]
);

   logic [DATA_W-1:0] row_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      localparam logic [ADDR_W-1:0] ROW_A = ADDR_W'(g);

      wr_src_e           src;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] bit_next;

      // Fixed priority: stack, byte port, register port, bit port
      always_comb begin
         src = SRC_NONE;
         if (stk_we && stk_addr == ROW_A)        src = SRC_STACK;
         else if (byte_we && byte_addr == ROW_A) src = SRC_BYTE;
         else if (reg_we && reg_addr == ROW_A)   src = SRC_REG;
         else if (bit_we && bit_byte == ROW_A)   src = SRC_BIT;
      end

      always_comb begin
         bit_next          = q;
         bit_next[bit_pos] = bit_val;
      end

      if (RESET_CLEAR) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else begin
               case (src)
                  SRC_STACK: q <= stk_data;
                  SRC_BYTE:  q <= byte_data;
                  SRC_REG:   q <= reg_data;
                  SRC_BIT:   q <= bit_next;
                  default:   q <= q;
               endcase
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            case (src)
               SRC_STACK: q <= stk_data;
               SRC_BYTE:  q <= byte_data;
               SRC_REG:   q <= reg_data;
               SRC_BIT:   q <= bit_next;
               default:   q <= q;
            endcase
         end
      end

      assign row_q[g] = q;
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = row_q[rd_addr[r]];
   end

endmodule

// File: rtl/banked_scratch_ram.sv
module banked_scratch_ram
   import bram_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int BANK_W      = 2,
   parameter int REG_W       = 3,
   parameter int BITADDR_W   = 7,
   parameter int BIT_BASE    = 32,
   parameter int SP_W        = 8,
   parameter int SP_RESET    = 7,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic [ADDR_W-1:0]    byte_addr,
   input  logic [DATA_W-1:0]    byte_wdata,
   input  logic                 byte_we,
   output logic [DATA_W-1:0]    byte_rdata,
   input  logic [REG_W-1:0]     reg_num,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic                 reg_we,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [BITADDR_W-1:0] bit_addr,
   input  logic                 bit_we,
   input  logic                 bit_wval,
   output logic                 bit_rdata,
   input  logic                 push_req,
   input  logic [DATA_W-1:0]    push_data,
   input  logic                 pop_req,
   output logic [DATA_W-1:0]    pop_data,
   output logic [SP_W-1:0]      sp_out
);

   localparam int DEPTH     = 1 << ADDR_W;
   localparam int BITPOS_W  = $clog2(DATA_W);
   localparam int BIT_BYTES = (1 << BITADDR_W) / DATA_W;
   localparam int BANK_SPAN = 1 << (BANK_W + REG_W);
   localparam int NRD       = 4;
   localparam int RD_BYTE   = 0;
   localparam int RD_REG    = 1;
   localparam int RD_BIT    = 2;
   localparam int RD_TOP    = 3;

   // Elaboration-time parameter checks
   if (BANK_SPAN > BIT_BASE) begin : g_bad_banks
      $error("register banks overlap the bit region");
   end
   if (BIT_BASE + BIT_BYTES > DEPTH) begin : g_bad_bitrange
      $error("bit region runs past the end of the storage");
   end
   if ((1 << BITPOS_W) != DATA_W) begin : g_bad_dataw
      $error("data width must be a power of two");
   end
   if (SP_W < ADDR_W) begin : g_bad_spw
      $error("stack pointer narrower than the address");
   end

   stk_op_e             stk_op;
   logic [ADDR_W-1:0]   push_addr;
   logic [ADDR_W-1:0]   top_addr;
   logic [ADDR_W-1:0]   reg_addr;
   logic [ADDR_W-1:0]   bit_byte;
   logic [BITPOS_W-1:0] bit_pos;
   logic [ADDR_W-1:0]   rd_addr [NRD];
   logic [DATA_W-1:0]   rd_data [NRD];
   logic                stk_we;
   logic [DATA_W-1:0]   bit_row;

   bram_stack_ctrl #(
      .SP_W     (SP_W),
      .ADDR_W   (ADDR_W),
      .SP_RESET (SP_RESET)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .op        (stk_op),
      .sp        (sp_out),
      .push_addr (push_addr),
      .top_addr  (top_addr)
   );

   bram_decode #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .REG_W     (REG_W),
      .BITADDR_W (BITADDR_W),
      .BITPOS_W  (BITPOS_W),
      .BIT_BASE  (BIT_BASE)
   ) u_decode (
      .bank_sel (bank_sel),
      .reg_num  (reg_num),
      .bit_addr (bit_addr),
      .reg_addr (reg_addr),
      .bit_byte (bit_byte),
      .bit_pos  (bit_pos)
   );

   assign stk_we           = (stk_op == STK_PUSH);
   assign rd_addr[RD_BYTE] = byte_addr;
   assign rd_addr[RD_REG]  = reg_addr;
   assign rd_addr[RD_BIT]  = bit_byte;
   assign rd_addr[RD_TOP]  = top_addr;

   bram_store #(
      .DEPTH       (DEPTH),
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .BITPOS_W    (BITPOS_W),
      .NRD         (NRD),
      .RESET_CLEAR (RESET_CLEAR)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .stk_we    (stk_we),
      .stk_addr  (push_addr),
      .stk_data  (push_data),
      .byte_we   (byte_we),
      .byte_addr (byte_addr),
      .byte_data (byte_wdata),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_data  (reg_wdata),
      .bit_we    (bit_we),
      .bit_byte  (bit_byte),
      .bit_pos   (bit_pos),
      .bit_val   (bit_wval),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   assign byte_rdata = rd_data[RD_BYTE];
   assign reg_rdata  = rd_data[RD_REG];
   assign pop_data   = rd_data[RD_TOP];
   assign bit_row    = rd_data[RD_BIT];
   assign bit_rdata  = bit_row[bit_pos];

endmodule

// File: rtl/bram_checker.sv
module bram_checker #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 7,
   parameter int BITADDR_W = 7,
   parameter int SP_W      = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    byte_addr,
   input logic [DATA_W-1:0]    byte_wdata,
   input logic                 byte_we,
   input logic [DATA_W-1:0]    byte_rdata,
   input logic                 reg_we,
   input logic [BITADDR_W-1:0] bit_addr,
   input logic                 bit_we,
   input logic                 bit_wval,
   input logic                 bit_rdata,
   input logic                 push_req,
   input logic [DATA_W-1:0]    push_data,
   input logic                 pop_req,
   input logic [DATA_W-1:0]    pop_data,
   input logic [SP_W-1:0]      sp_out
);

   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   p_push_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req) |=> (sp_out == $past(sp_out) + ONE) && (pop_data == $past(push_data)));

   p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req) |=> (sp_out == $past(sp_out) - ONE));

   p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req == pop_req) |=> $stable(sp_out));

   p_byte_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we && !push_req) |=> (byte_addr != $past(byte_addr)) || (byte_rdata == $past(byte_wdata)));

   p_bit_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_we && !byte_we && !reg_we && !push_req) |=>
         (bit_addr != $past(bit_addr)) || (bit_rdata == $past(bit_wval)));

endmodule

bind banked_scratch_ram bram_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BITADDR_W (BITADDR_W),
   .SP_W      (SP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_addr  (byte_addr),
   .byte_wdata (byte_wdata),
   .byte_we    (byte_we),
   .byte_rdata (byte_rdata),
   .reg_we     (reg_we),
   .bit_addr   (bit_addr),
   .bit_we     (bit_we),
   .bit_wval   (bit_wval),
   .bit_rdata  (bit_rdata),
   .push_req   (push_req),
   .push_data  (push_data),
   .pop_req    (pop_req),
   .pop_data   (pop_data),
   .sp_out     (sp_out)
);

// File: tb/tb_banked_scratch_ram.sv
module tb_banked_scratch_ram;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] bank_sel;
   logic [6:0] byte_addr;
   logic [7:0] byte_wdata;
   logic       byte_we;
   logic [7:0] byte_rdata;
   logic [2:0] reg_num;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic [6:0] bit_addr;
   logic       bit_we;
   logic       bit_wval;
   logic       bit_rdata;
   logic       push_req;
   logic [7:0] push_data;
   logic       pop_req;
   logic [7:0] pop_data;
   logic [7:0] sp_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_scratch_ram dut (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
      .byte_addr(byte_addr), .byte_wdata(byte_wdata), .byte_we(byte_we), .byte_rdata(byte_rdata),
      .reg_num(reg_num), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .bit_addr(bit_addr), .bit_we(bit_we), .bit_wval(bit_wval), .bit_rdata(bit_rdata),
      .push_req(push_req), .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
      .sp_out(sp_out)
   );

   typedef struct packed {
      logic [1:0] bank;
      logic [2:0] rn;
      logic       rwe;
      logic [7:0] rd;
      logic [6:0] ba;
      logic       bwe;
      logic [7:0] bd;
      logic [7:0] exp_r;
      logic [7:0] exp_b;
   } vec_t;

   // Register-port and byte-port vectors; bank k, reg n lands on byte 8k+n
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 3'd3, 1'b1, 8'h11, 7'h05, 1'b1, 8'h22, 8'h11, 8'h22},
      '{2'd1, 3'd0, 1'b1, 8'h33, 7'h08, 1'b0, 8'h00, 8'h33, 8'h33},
      '{2'd3, 3'd7, 1'b1, 8'h44, 7'h1F, 1'b0, 8'h00, 8'h44, 8'h44},
      '{2'd2, 3'd5, 1'b1, 8'h55, 7'h15, 1'b1, 8'h66, 8'h66, 8'h66},
      '{2'd0, 3'd3, 1'b0, 8'h00, 7'h03, 1'b0, 8'h00, 8'h11, 8'h11},
      '{2'd1, 3'd7, 1'b0, 8'h00, 7'h0F, 1'b1, 8'h77, 8'h77, 8'h77},
      '{2'd2, 3'd0, 1'b1, 8'h88, 7'h40, 1'b1, 8'h99, 8'h88, 8'h99},
      '{2'd3, 3'd0, 1'b0, 8'h00, 7'h7F, 1'b1, 8'hAA, 8'h00, 8'hAA}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      byte_we  = 1'b0;
      reg_we   = 1'b0;
      bit_we   = 1'b0;
      push_req = 1'b0;
      pop_req  = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      bank_sel = '0; byte_addr = '0; byte_wdata = '0; reg_num = '0; reg_wdata = '0;
      bit_addr = '0; bit_wval = 1'b0; push_data = '0;
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      byte_addr = 7'h7F; bank_sel = 2'd3; reg_num = 3'd7;
      #1;
      chk("R1 sp", sp_out, 8'h07);
      chk("R1 pop_data", pop_data, 8'h00);
      chk("R1 byte 7F", byte_rdata, 8'h00);
      chk("R1 reg b3r7", reg_rdata, 8'h00);

      // R2 R3 R6: vector walk
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         idle();
         bank_sel   = VEC[i].bank;
         reg_num    = VEC[i].rn;
         reg_we     = VEC[i].rwe;
         reg_wdata  = VEC[i].rd;
         byte_addr  = VEC[i].ba;
         byte_we    = VEC[i].bwe;
         byte_wdata = VEC[i].bd;
         tick();
         chk("R2 reg view", reg_rdata, VEC[i].exp_r);
         chk("R3 byte view", byte_rdata, VEC[i].exp_b);
      end

      // R4: bit 0 of byte 20h
      @(negedge clk); idle();
      bit_addr = 7'h00; bit_we = 1'b1; bit_wval = 1'b1; byte_addr = 7'h20;
      tick();
      chk("R4 byte20", byte_rdata, 8'h01);
      chk("R4 bit00", {7'd0, bit_rdata}, 8'h01);

      // R4: bit address 0Fh is bit 7 of byte 21h
      @(negedge clk); idle();
      bit_addr = 7'h0F; bit_we = 1'b1; bit_wval = 1'b1; byte_addr = 7'h21;
      tick();
      chk("R4 byte21", byte_rdata, 8'h80);

      // R4: top bit address 7Fh is bit 7 of byte 2Fh
      @(negedge clk); idle();
      bit_addr = 7'h7F; bit_we = 1'b1; bit_wval = 1'b1; byte_addr = 7'h2F;
      tick();
      chk("R4 byte2F", byte_rdata, 8'h80);

      // R5: single-bit changes keep the other bits
      @(negedge clk); idle();
      byte_addr = 7'h23; byte_wdata = 8'h5A; byte_we = 1'b1;
      tick();
      @(negedge clk); idle();
      bit_addr = 7'h18; bit_we = 1'b1; bit_wval = 1'b1;
      tick();
      chk("R5 set bit0", byte_rdata, 8'h5B);
      @(negedge clk); idle();
      bit_addr = 7'h1E; bit_we = 1'b1; bit_wval = 1'b0;
      tick();
      chk("R5 clear bit6", byte_rdata, 8'h1B);
      chk("R5 bit1E read", {7'd0, bit_rdata}, 8'h00);

      // R6: byte port beats bit port on the same byte
      @(negedge clk); idle();
      byte_addr = 7'h22; byte_wdata = 8'hA5; byte_we = 1'b1;
      bit_addr = 7'h10; bit_we = 1'b1; bit_wval = 1'b0;
      tick();
      chk("R6 byte over bit", byte_rdata, 8'hA5);

      // R7: pushes
      @(negedge clk); idle();
      push_req = 1'b1; push_data = 8'hC1; byte_addr = 7'h08;
      tick();
      chk("R7 sp after push", sp_out, 8'h08);
      chk("R7 top after push", pop_data, 8'hC1);
      chk("R7 byte08", byte_rdata, 8'hC1);
      @(negedge clk); idle();
      push_req = 1'b1; push_data = 8'hC2;
      tick();
      chk("R7 sp second push", sp_out, 8'h09);
      chk("R7 top second push", pop_data, 8'hC2);

      // R9: push beats a byte write to the same byte
      @(negedge clk); idle();
      push_req = 1'b1; push_data = 8'hC3;
      byte_addr = 7'h0A; byte_wdata = 8'hEE; byte_we = 1'b1;
      tick();
      @(negedge clk); idle();
      #1;
      chk("R9 push over byte", byte_rdata, 8'hC3);
      chk("R9 sp", sp_out, 8'h0A);

      // R8: pop
      @(negedge clk); idle();
      pop_req = 1'b1;
      tick();
      chk("R8 sp after pop", sp_out, 8'h09);
      chk("R8 top after pop", pop_data, 8'hC2);
      chk("R8 popped byte kept", byte_rdata, 8'hC3);

      // R10: push and pop together do nothing
      @(negedge clk); idle();
      push_req = 1'b1; pop_req = 1'b1; push_data = 8'h77;
      tick();
      chk("R10 sp held", sp_out, 8'h09);
      chk("R10 top held", pop_data, 8'hC2);
      chk("R10 byte0A held", byte_rdata, 8'hC3);

      // R8: pop back to the reset pointer
      @(negedge clk); idle();
      pop_req = 1'b1;
      tick();
      chk("R8 top C1", pop_data, 8'hC1);
      @(negedge clk); idle();
      pop_req = 1'b1;
      tick();
      chk("R8 sp 07", sp_out, 8'h07);
      chk("R8 top byte07", pop_data, 8'h00);

      @(negedge clk); idle();
      summary();
   end

endmodule